// File: doc/BRIEF.md
# Guarded Flash Control Register

This block is an 8-bit control register for an on-chip flash controller. It sits on a plain CPU bus with an address, write and read strobes, write data and registered read data. It holds seven control bits:

- a rewrite-mode enable
- a select between two erase/write modes
- a flash-stop request
- a self-clearing sequence-abort strobe
- three interrupt enables

Each control bit leaves the block as a registered output. The abort strobe is different: it leaves as a one-cycle pulse to the erase/write sequencer.

Writes are checked against three live status inputs from the sequencer: ready/busy, a pending ready-interrupt request and a pending access-error request. Some writes are accepted only in part, or not at all, depending on those inputs. The rewrite enable is guarded by a two-step unlock: software must write 0 to it and then, as its very next access to this register, write 1. Software reads back the stored bits, with the reserved bit and the abort bit always returned as 0.

Top module: `flash_ctl_guard`

## Requirements
- R1: After a synchronous reset, every control output is 0, a read returns 0x00 and no abort pulse is produced.
- R2: The interrupt enables (bit 7 ready, bit 6 access error, bit 5 erase/write error) and the mode select (bit 2) take the written value in a single write, whatever the status inputs are.
- R3: Read data is valid the cycle after the read strobe. Bit 0 (reserved) and bit 4 (abort) always read as 0, whatever was written.
- R4: A write of 1 to the rewrite enable (bit 1) that does not directly follow a write of 0 to it leaves the enable at 0.
- R5: A write of 1 to bit 1 directly after a write of 0 to bit 1 sets the rewrite enable. Idle bus cycles between the two writes do not break the unlock.
- R6: A write to any other address, or a read of this register, between the two unlock writes cancels the unlock.
- R7: A write of 0 to bit 1 clears the rewrite enable only when both the ready-interrupt request and the access-error request are inactive. Otherwise the enable stays 1.
- R8: Writes to the flash-stop bit (bit 3) are ignored while rewrite mode is disabled. Setting it from 0 to 1 also requires the sequencer to report ready.
- R9: The flash-stop output is 0 whenever the rewrite enable is 0. Clearing the enable also clears the stop bit.
- R10: A write with bit 4 set produces exactly one cycle of abort pulse, the cycle after the write, and only while rewrite mode is enabled and the sequencer reports busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| seq_ready | input | 1 | Sequencer ready (1) or busy (0) |
| rdy_irq_pend | input | 1 | Ready-interrupt request pending |
| acc_err_pend | input | 1 | Access-error request pending |
| rew_en | output | 1 | Rewrite mode enabled |
| mode_sel | output | 1 | Erase/write mode select |
| flash_stop | output | 1 | Flash stop request |
| seq_abort | output | 1 | One-cycle sequencer abort pulse |
| err_ie | output | 1 | Erase/write-error interrupt enable |
| acc_ie | output | 1 | Access-error interrupt enable |
| rdy_ie | output | 1 | Ready interrupt enable |

## Verification
A wrong unlock state shows up on `rew_en` one cycle after the second unlock write. Either the enable rises after a lone write of 1, or it stays low after a clean 0-then-1 pair. Stale or ungated state in the stop and enable flops is visible on the outputs the cycle after the offending write, and a read issued straight afterwards brings out the stored byte one cycle later. An ungated or stretched abort shows up as a pulse count that is wrong within two cycles of the write carrying bit 4.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam int DATA_W    = 8;
  localparam int BIT_RSV   = 0;
  localparam int BIT_REW   = 1;
  localparam int BIT_MODE  = 2;
  localparam int BIT_STOP  = 3;
  localparam int BIT_ABORT = 4;
  localparam int BIT_ERRIE = 5;
  localparam int BIT_ACCIE = 6;
  localparam int BIT_RDYIE = 7;

  typedef struct packed {
    logic rdy_ie;
    logic acc_ie;
    logic err_ie;
    logic stop;
    logic mode;
    logic rew;
  } fcr_ctl_t;

  function automatic logic [DATA_W-1:0] ctl_to_byte(fcr_ctl_t c);
    logic [DATA_W-1:0] b;
    b = '0;
    b[BIT_REW]   = c.rew;
    b[BIT_MODE]  = c.mode;
    b[BIT_STOP]  = c.stop;
    b[BIT_ERRIE] = c.err_ie;
    b[BIT_ACCIE] = c.acc_ie;
    b[BIT_RDYIE] = c.rdy_ie;
    return b;
  endfunction
endpackage

// File: rtl/fcr_unlock.sv
module fcr_unlock (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic wr_other,
  input  logic rd_hit,
  input  logic wbit_rew,
  output logic armed
);
  // Armed after a write of 0 to the enable bit; any write to this register
  // consumes the state, other writes or a read of this register cancel it.
  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
    end else if (wr_hit) begin
      armed <= ~wbit_rew;
    end else if (wr_other || rd_hit) begin
      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/fcr_gate.sv
module fcr_gate
  import fcr_pkg::*;
(
  input  fcr_ctl_t          cur,
  input  logic              wr_hit,
  input  logic              armed,
  input  logic [DATA_W-1:0] wdata,
  input  logic              seq_ready,
  input  logic              rdy_irq_pend,
  input  logic              acc_err_pend,
  output fcr_ctl_t          nxt,
  output logic              abort_req
);
  logic clear_blocked;

  always_comb begin
    clear_blocked = rdy_irq_pend | acc_err_pend;
    nxt = cur;
    if (wr_hit) begin
      nxt.rdy_ie = wdata[BIT_RDYIE];
      nxt.acc_ie = wdata[BIT_ACCIE];
      nxt.err_ie = wdata[BIT_ERRIE];
      nxt.mode   = wdata[BIT_MODE];
      if (wdata[BIT_REW]) begin
        nxt.rew = cur.rew | armed;
      end else begin
        nxt.rew = cur.rew & clear_blocked;
      end
      if (cur.rew) begin
        nxt.stop = wdata[BIT_STOP] ? (cur.stop | seq_ready) : 1'b0;
      end
    end
    if (!nxt.rew) begin
      nxt.stop = 1'b0;
    end
    abort_req = wr_hit & wdata[BIT_ABORT] & cur.rew & ~seq_ready;
  end
endmodule

// File: rtl/fcr_rdport.sv
module fcr_rdport
  import fcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_hit,
  input  fcr_ctl_t          cur,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_hit) begin
      rdata <= ctl_to_byte(cur);
    end
  end
endmodule

// File: rtl/flash_ctl_guard.sv
module flash_ctl_guard
  import fcr_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              seq_ready,
  input  logic              rdy_irq_pend,
  input  logic              acc_err_pend,
  output logic              rew_en,
  output logic              mode_sel,
  output logic              flash_stop,
  output logic              seq_abort,
  output logic              err_ie,
  output logic              acc_ie,
  output logic              rdy_ie
);
  logic     sel;
  logic     wr_hit;
  logic     wr_other;
  logic     rd_hit;
  logic     armed;
  logic     abort_req;
  fcr_ctl_t ctl_q;
  fcr_ctl_t ctl_d;

  assign sel      = (bus_addr == REG_ADDR);
  assign wr_hit   = bus_wr & sel;
  assign wr_other = bus_wr & ~sel;
  assign rd_hit   = bus_rd & sel;

  fcr_unlock u_unlock (
    .clk      (clk),
    .rst      (rst),
    .wr_hit   (wr_hit),
    .wr_other (wr_other),
    .rd_hit   (rd_hit),
    .wbit_rew (bus_wdata[BIT_REW]),
    .armed    (armed)
  );

  fcr_gate u_gate (
    .cur          (ctl_q),
    .wr_hit       (wr_hit),
    .armed        (armed),
    .wdata        (bus_wdata),
    .seq_ready    (seq_ready),
    .rdy_irq_pend (rdy_irq_pend),
    .acc_err_pend (acc_err_pend),
    .nxt          (ctl_d),
    .abort_req    (abort_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      seq_abort <= 1'b0;
    end else begin
      ctl_q     <= ctl_d;
      seq_abort <= abort_req;
    end
  end

  fcr_rdport u_rdport (
    .clk    (clk),
    .rst    (rst),
    .rd_hit (rd_hit),
    .cur    (ctl_q),
    .rdata  (bus_rdata)
  );

  assign rew_en     = ctl_q.rew;
  assign mode_sel   = ctl_q.mode;
  assign flash_stop = ctl_q.stop;
  assign err_ie     = ctl_q.err_ie;
  assign acc_ie     = ctl_q.acc_ie;
  assign rdy_ie     = ctl_q.rdy_ie;
endmodule

// File: rtl/flash_ctl_guard_chk.sv
module flash_ctl_guard_chk #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h3C
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              seq_ready,
  input logic              rdy_irq_pend,
  input logic              acc_err_pend,
  input logic              rew_en,
  input logic              flash_stop,
  input logic              seq_abort
);
  logic wr_here;
  assign wr_here = bus_wr && (bus_addr == REG_ADDR);

  p_rsv_bits_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata[0] == 1'b0) && (bus_rdata[4] == 1'b0));

  // R4, R5: the enable can only rise from a write of 1 to its bit
  p_set_by_write_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(rew_en) |-> $past(wr_here && bus_wdata[1]));

  p_clear_gated_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(rew_en) |-> $past(!rdy_irq_pend && !acc_err_pend));

  p_stop_set_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(flash_stop) |-> $past(seq_ready && rew_en));

  p_stop_needs_rew_r9: assert property (@(posedge clk) disable iff (rst)
    flash_stop |-> rew_en);

  p_abort_width_r10: assert property (@(posedge clk) disable iff (rst)
    seq_abort |=> !seq_abort);

  p_abort_cause_r10: assert property (@(posedge clk) disable iff (rst)
    seq_abort |-> $past(wr_here && bus_wdata[4] && rew_en && !seq_ready));
endmodule

bind flash_ctl_guard flash_ctl_guard_chk #(
  .ADDR_W   (ADDR_W),
  .REG_ADDR (REG_ADDR)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .seq_ready    (seq_ready),
  .rdy_irq_pend (rdy_irq_pend),
  .acc_err_pend (acc_err_pend),
  .rew_en       (rew_en),
  .flash_stop   (flash_stop),
  .seq_abort    (seq_abort)
);

// File: tb/flash_ctl_guard_bench.sv
module flash_ctl_guard_bench;
  localparam int         ADDR_W = 8;
  localparam logic [7:0] RA     = 8'h3C;
  localparam logic [7:0] OTHER  = 8'h3D;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       seq_ready = 1'b1;
  logic       rdy_irq_pend = 1'b0;
  logic       acc_err_pend = 1'b0;
  logic rew_en, mode_sel, flash_stop, seq_abort, err_ie, acc_ie, rdy_ie;

  int n_cmp = 0;
  int n_bad = 0;
  int pulses = 0;
  logic rd_seen = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  flash_ctl_guard #(.ADDR_W(ADDR_W), .REG_ADDR(RA)) u_flash_ctl_guard (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .seq_ready(seq_ready),
    .rdy_irq_pend(rdy_irq_pend), .acc_err_pend(acc_err_pend), .rew_en(rew_en),
    .mode_sel(mode_sel), .flash_stop(flash_stop), .seq_abort(seq_abort),
    .err_ie(err_ie), .acc_ie(acc_ie), .rdy_ie(rdy_ie)
  );

  function automatic logic [7:0] outs();
    return {rdy_ie, acc_ie, err_ie, 1'b0, flash_stop, mode_sel, rew_en, 1'b0};
  endfunction

  task automatic cmp(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver side of the scoreboard: issue a read, queue its expected byte
  task automatic rd(logic [7:0] exp, string req);
    @(negedge clk);
    bus_addr = RA; bus_rd = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  always @(posedge clk) begin
    rd_seen <= bus_rd && (bus_addr == RA);
    if (!rst && seq_abort) pulses++;
  end

  // monitor side: compare read data one cycle after the strobe
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R3: unexpected read data %h expected none", bus_rdata);
      end else begin
        cmp(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cmp("R1 outputs", outs(), 8'h00);
    cmp("R1 abort", {7'd0, seq_abort}, 8'h00);
    rd(8'h00, "R1 read");

    wr(RA, 8'hE4);
    cmp("R2 outputs", outs(), 8'hE4);
    rd(8'hE4, "R2 read");

    wr(RA, 8'hF5);
    cmp("R3 outputs", outs(), 8'hE4);
    rd(8'hE4, "R3 read");
    cmp("R10 no pulse rew off", pulses[7:0], 8'd0);

    wr(RA, 8'h0A);
    cmp("R4 lone one / R8 stop ignored", outs(), 8'h00);

    wr(RA, 8'h00); wr(OTHER, 8'h00); wr(RA, 8'h02);
    cmp("R6 other write", outs(), 8'h00);
    wr(RA, 8'h00); rd(8'h00, "R6 read"); wr(RA, 8'h02);
    cmp("R6 read between", outs(), 8'h00);

    wr(RA, 8'h00);
    repeat (3) @(negedge clk);
    wr(RA, 8'h02);
    cmp("R5 unlock", outs(), 8'h02);

    seq_ready = 1'b0;
    wr(RA, 8'h0A);
    cmp("R8 stop busy", outs(), 8'h02);
    seq_ready = 1'b1;
    wr(RA, 8'h0A);
    cmp("R8 stop ready", outs(), 8'h0A);
    rd(8'h0A, "R3 read stop");

    wr(RA, 8'h1A);
    cmp("R10 ready no pulse", pulses[7:0], 8'd0);
    seq_ready = 1'b0;
    wr(RA, 8'h1A);
    repeat (3) @(negedge clk);
    cmp("R10 one pulse", pulses[7:0], 8'd1);
    cmp("R10 state kept", outs(), 8'h0A);
    seq_ready = 1'b1;

    rdy_irq_pend = 1'b1;
    wr(RA, 8'h08);
    cmp("R7 rdy pending", outs(), 8'h0A);
    rdy_irq_pend = 1'b0; acc_err_pend = 1'b1;
    wr(RA, 8'h08);
    cmp("R7 acc pending", outs(), 8'h0A);
    acc_err_pend = 1'b0;
    wr(RA, 8'h08);
    cmp("R7 R9 clear", outs(), 8'h00);
    rd(8'h00, "R9 read");

    seq_ready = 1'b0;
    wr(RA, 8'h10);
    repeat (2) @(negedge clk);
    cmp("R10 busy rew off", pulses[7:0], 8'd1);
    seq_ready = 1'b1;

    repeat (3) @(negedge clk);
    cmp("R3 queue drained", 8'(exp_q.size()), 8'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule